// File: doc/BRIEF.md
# Per-Line Directory Coherence Controller

This block tracks the coherence state of one cached line on the cache side of a directory-based protocol. It holds the line's data and a pending write value, accepts processor read, write and evict requests, and reacts to messages from the network. The network can send an invalidation, a forwarded read request, a forwarded ownership request, an acknowledgement of a write-back, a data reply, or the final invalidation acknowledgement. The block answers with outgoing GetS, GetM, PutM, Ack and Data messages.

There are four stable states: I, S, O and M. Nine transient states cover an outstanding miss or eviction. They also cover the races that occur when another node's request reaches this line before the line's own miss has completed. While the line is transient, the processor is stalled. Any message that cannot occur in the current state raises a sticky protocol-error flag.

Flow rules for the processor request port (valid/ready):
- A request is taken only on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high.
- `cpu_req_ready` is low in every transient state.
- `cpu_req_ready` is also low on any cycle where a network message is present, because network traffic takes priority.

Flow rules for the network port and the outgoing message port:
- Every network message is consumed on the cycle it is valid. This port has no back-pressure.
- Outgoing messages, `cpu_done` and `cpu_rdata` are registered single-cycle pulses. They appear in the cycle after the event that caused them. The sink must take each outgoing message as it comes.

Top module: `coh_line_ctl`

## Requirements
- R1: After reset, `line_state` is 0 (I), and `proto_err`, `msg_out_valid` and `cpu_done` are all 0. The state codes are: I=0, S=1, O=2, M=3, IS=4, ISI=5, IM=6, IMI=7, IMO=8, IMOI=9, OI=10, MI=11, OM=12.
- R2: Processor op codes are read=0, write=1 and evict=2. Outgoing message codes are GetS=0, GetM=1, PutM=2, Ack=3 and Data=4. In I, the processor ops behave as follows:
  - a read sends GetS and moves to IS;
  - a write latches its data, sends GetM and moves to IM;
  - an evict sends nothing and stays in I.
- R3: In S, the processor ops and an invalidation behave as follows:
  - a read completes with the line data;
  - a write sends GetM and moves to IM;
  - an evict moves to I with no message;
  - an invalidation sends Ack and moves to I.
- R4: In O and M, a read completes with the line data. The other processor ops behave as follows:
  - a write in M completes at once and updates the line;
  - a write in O sends GetM and moves to OM;
  - an evict sends PutM carrying the line, moving O to OI and M to MI.
- R5: Network message codes are Inv=0, FwdGetS=1, FwdGetM=2, PutAck=3, Data=4 and LastAck=5. In O or M, a FwdGetS is answered with Data carrying the line and the line ends in O. A FwdGetM is answered with Data carrying the line and the line moves to I.
- R6: In every transient state, `cpu_stall` is 1 and `cpu_req_ready` is 0. A request offered during a transient state has no effect on the state, the messages or `cpu_done`.
- R7: In IS or ISI, an invalidation sends Ack and moves to ISI. A data reply completes the read with the reply's data, moving IS to S and ISI to I.
- R8: Races while the line's own write miss is outstanding are handled as follows:
  - In IM, an invalidation sends Ack and stays in IM; a FwdGetS moves to IMO; a FwdGetM moves to IMI.
  - In IMO, an invalidation sends Ack and moves to IMI; a FwdGetM moves to IMOI.
  - A data reply completes the write. The line ends in M from IM. From IMO it sends Data carrying the written value and ends in O. From IMI or IMOI it sends Data carrying the written value and ends in I.
- R9: In OI or MI, a FwdGetS is answered with Data and the state is kept. A FwdGetM is answered with Data and the line moves to I. A PutAck moves the line to I with no message.
- R10: In OM, a FwdGetS is answered with Data and the line stays in OM. A FwdGetM is answered with Data and the line falls back to IM. A LastAck completes the write and the line ends in M.
- R11: Any other combination of state and event raises `proto_err`: every message in I, network codes 6 and 7, and processor op 3. Such an event leaves the state unchanged and sends nothing. `proto_err` stays high until reset.
- R12: A network message and a processor request offered on the same cycle are handled as follows: only the network message is acted on, and `cpu_req_ready` is 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | Processor op: read=0, write=1, evict=2 |
| cpu_req_wdata | input | DW | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_stall | output | 1 | Line is in a transient state |
| cpu_done | output | 1 | Read or write completion pulse |
| cpu_rdata | output | DW | Read data, valid with a read completion |
| net_in_valid | input | 1 | Network message present |
| net_in_type | input | 3 | Network message code |
| net_in_data | input | DW | Data carried by a data reply |
| msg_out_valid | output | 1 | Outgoing message pulse |
| msg_out_type | output | 3 | Outgoing message code |
| msg_out_data | output | DW | Line data for PutM/Data, else 0 |
| line_state | output | 4 | Current coherence state code |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
A wrong internal state is visible on `line_state` one cycle after the event that caused it, so every state-and-event pair is checked on the following cycle. The error is visible by other routes as well:
- A wrong next state also changes how the next event is handled. A state that is off by one transient step can either raise `proto_err` on a message that should have been legal, or send Data where nothing should be sent.
- A corrupted pending write value is only seen later, in the Data or PutM payload, or in a read after the miss completes. For this reason, payloads are compared on every message that carries data.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [3:0] {
    ST_I    = 4'd0,
    ST_S    = 4'd1,
    ST_O    = 4'd2,
    ST_M    = 4'd3,
    ST_IS   = 4'd4,
    ST_ISI  = 4'd5,
    ST_IM   = 4'd6,
    ST_IMI  = 4'd7,
    ST_IMO  = 4'd8,
    ST_IMOI = 4'd9,
    ST_OI   = 4'd10,
    ST_MI   = 4'd11,
    ST_OM   = 4'd12
  } line_st_t;

  localparam logic [1:0] OP_RD    = 2'd0;
  localparam logic [1:0] OP_WR    = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;

  localparam logic [2:0] NI_INV      = 3'd0;
  localparam logic [2:0] NI_FWD_GETS = 3'd1;
  localparam logic [2:0] NI_FWD_GETM = 3'd2;
  localparam logic [2:0] NI_PUT_ACK  = 3'd3;
  localparam logic [2:0] NI_DATA     = 3'd4;
  localparam logic [2:0] NI_LAST_ACK = 3'd5;

  localparam logic [2:0] MO_GETS = 3'd0;
  localparam logic [2:0] MO_GETM = 3'd1;
  localparam logic [2:0] MO_PUTM = 3'd2;
  localparam logic [2:0] MO_ACK  = 3'd3;
  localparam logic [2:0] MO_DATA = 3'd4;

  typedef struct packed {
    line_st_t   nxt;
    logic       fault;
    logic       snd;
    logic [2:0] snd_ty;
    logic       snd_pend;
    logic       done;
    logic       rd_net;
    logic       rd_line;
    logic       ld_pend;
    logic       ld_line_cpu;
    logic       ld_line_net;
    logic       ld_line_pend;
  } act_t;

  function automatic logic is_transient(line_st_t s);
    return s >= ST_IS;
  endfunction

  function automatic act_t go(line_st_t n);
    act_t a;
    a = '0;
    a.nxt = n;
    return a;
  endfunction

  function automatic act_t go_snd(line_st_t n, logic [2:0] ty);
    act_t a;
    a = go(n);
    a.snd = 1'b1;
    a.snd_ty = ty;
    return a;
  endfunction

  function automatic act_t bad(line_st_t cur);
    act_t a;
    a = go(cur);
    a.fault = 1'b1;
    return a;
  endfunction

endpackage

// File: rtl/coh_fsm_next.sv
module coh_fsm_next
  import coh_pkg::*;
(
  input  line_st_t   st,
  input  logic       cpu_fire,
  input  logic [1:0] cpu_op,
  input  logic       net_fire,
  input  logic [2:0] net_ty,
  output act_t       a
);

  always_comb begin
    a = go(st);
    if (net_fire) begin
      a = bad(st);
      case (st)
        ST_S: if (net_ty == NI_INV) a = go_snd(ST_I, MO_ACK);
        ST_O, ST_M: begin
          if (net_ty == NI_FWD_GETS)      a = go_snd(ST_O, MO_DATA);
          else if (net_ty == NI_FWD_GETM) a = go_snd(ST_I, MO_DATA);
        end
        ST_IS, ST_ISI: begin
          if (net_ty == NI_INV) a = go_snd(ST_ISI, MO_ACK);
          else if (net_ty == NI_DATA) begin
            a = go((st == ST_IS) ? ST_S : ST_I);
            a.done = 1'b1;
            a.rd_net = 1'b1;
            a.ld_line_net = 1'b1;
          end
        end
        ST_IM: begin
          if (net_ty == NI_INV)           a = go_snd(ST_IM, MO_ACK);
          else if (net_ty == NI_FWD_GETS) a = go(ST_IMO);
          else if (net_ty == NI_FWD_GETM) a = go(ST_IMI);
          else if (net_ty == NI_DATA) begin
            a = go(ST_M);
            a.done = 1'b1;
            a.ld_line_pend = 1'b1;
          end
        end
        ST_IMO: begin
          if (net_ty == NI_INV)           a = go_snd(ST_IMI, MO_ACK);
          else if (net_ty == NI_FWD_GETM) a = go(ST_IMOI);
          else if (net_ty == NI_DATA) begin
            a = go_snd(ST_O, MO_DATA);
            a.snd_pend = 1'b1;
            a.done = 1'b1;
            a.ld_line_pend = 1'b1;
          end
        end
        ST_IMI, ST_IMOI: begin
          if (net_ty == NI_DATA) begin
            a = go_snd(ST_I, MO_DATA);
            a.snd_pend = 1'b1;
            a.done = 1'b1;
            a.ld_line_pend = 1'b1;
          end
        end
        ST_OI, ST_MI: begin
          if (net_ty == NI_FWD_GETS)      a = go_snd(st, MO_DATA);
          else if (net_ty == NI_FWD_GETM) a = go_snd(ST_I, MO_DATA);
          else if (net_ty == NI_PUT_ACK)  a = go(ST_I);
        end
        ST_OM: begin
          if (net_ty == NI_FWD_GETS)      a = go_snd(ST_OM, MO_DATA);
          else if (net_ty == NI_FWD_GETM) a = go_snd(ST_IM, MO_DATA);
          else if (net_ty == NI_LAST_ACK) begin
            a = go(ST_M);
            a.done = 1'b1;
            a.ld_line_pend = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (cpu_fire) begin
      a = bad(st);
      case (st)
        ST_I: begin
          if (cpu_op == OP_RD) a = go_snd(ST_IS, MO_GETS);
          else if (cpu_op == OP_WR) begin
            a = go_snd(ST_IM, MO_GETM);
            a.ld_pend = 1'b1;
          end
          else if (cpu_op == OP_EVICT) a = go(ST_I);
        end
        ST_S, ST_O, ST_M: begin
          if (cpu_op == OP_RD) begin
            a = go(st);
            a.done = 1'b1;
            a.rd_line = 1'b1;
          end else if (cpu_op == OP_WR) begin
            if (st == ST_M) begin
              a = go(ST_M);
              a.done = 1'b1;
              a.ld_line_cpu = 1'b1;
            end else begin
              a = go_snd((st == ST_O) ? ST_OM : ST_IM, MO_GETM);
              a.ld_pend = 1'b1;
            end
          end else if (cpu_op == OP_EVICT) begin
            if (st == ST_S) a = go(ST_I);
            else            a = go_snd((st == ST_O) ? ST_OI : ST_MI, MO_PUTM);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_pend,
  input  logic          ld_line_cpu,
  input  logic          ld_line_net,
  input  logic          ld_line_pend,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] net_data,
  output logic [DW-1:0] line_q,
  output logic [DW-1:0] pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      if (ld_pend) pend_q <= cpu_wdata;
      if (ld_line_cpu)       line_q <= cpu_wdata;
      else if (ld_line_net)  line_q <= net_data;
      else if (ld_line_pend) line_q <= pend_q;
    end
  end

endmodule

// File: rtl/coh_line_ctl.sv
module coh_line_ctl
  import coh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  input  logic [1:0]    cpu_req_op,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  input  logic          net_in_valid,
  input  logic [2:0]    net_in_type,
  input  logic [DW-1:0] net_in_data,
  output logic          msg_out_valid,
  output logic [2:0]    msg_out_type,
  output logic [DW-1:0] msg_out_data,
  output logic [3:0]    line_state,
  output logic          proto_err
);

  line_st_t      st_q;
  act_t          act;
  logic          cpu_fire;
  logic [DW-1:0] line_q, pend_q;
  logic [DW-1:0] snd_data, rd_data;

  assign cpu_stall     = is_transient(st_q);
  assign cpu_req_ready = !cpu_stall && !net_in_valid;
  assign cpu_fire      = cpu_req_valid && cpu_req_ready;
  assign line_state    = st_q;

  coh_fsm_next u_next (
    .st       (st_q),
    .cpu_fire (cpu_fire),
    .cpu_op   (cpu_req_op),
    .net_fire (net_in_valid),
    .net_ty   (net_in_type),
    .a        (act)
  );

  coh_line_store #(.DW(DW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_pend      (act.ld_pend),
    .ld_line_cpu  (act.ld_line_cpu),
    .ld_line_net  (act.ld_line_net),
    .ld_line_pend (act.ld_line_pend),
    .cpu_wdata    (cpu_req_wdata),
    .net_data     (net_in_data),
    .line_q       (line_q),
    .pend_q       (pend_q)
  );

  assign snd_data = (act.snd && (act.snd_ty == MO_DATA || act.snd_ty == MO_PUTM))
                    ? (act.snd_pend ? pend_q : line_q) : '0;
  assign rd_data  = act.rd_net ? net_in_data : (act.rd_line ? line_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_I;
      proto_err     <= 1'b0;
      msg_out_valid <= 1'b0;
      msg_out_type  <= '0;
      msg_out_data  <= '0;
      cpu_done      <= 1'b0;
      cpu_rdata     <= '0;
    end else begin
      st_q          <= act.nxt;
      proto_err     <= proto_err | act.fault;
      msg_out_valid <= act.snd;
      msg_out_type  <= act.snd ? act.snd_ty : '0;
      msg_out_data  <= snd_data;
      cpu_done      <= act.done;
      cpu_rdata     <= rd_data;
    end
  end

endmodule

// File: rtl/coh_line_ctl_chk.sv
module coh_line_ctl_chk
  import coh_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_valid,
  input logic [1:0] cpu_req_op,
  input logic       cpu_req_ready,
  input logic       cpu_done,
  input logic       net_in_valid,
  input logic [2:0] net_in_type,
  input logic       msg_out_valid,
  input logic [2:0] msg_out_type,
  input logic [3:0] line_state,
  input logic       proto_err
);

  // R6
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state >= ST_IS) |-> !cpu_req_ready);

  // R12
  net_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_in_valid |-> !cpu_req_ready);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R11
  bad_net_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (net_in_valid && net_in_type > NI_LAST_ACK) |=> proto_err);

  // R2
  gets_only_in_is_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_out_valid && msg_out_type == MO_GETS) |-> (line_state == ST_IS));

  // R4
  m_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == ST_M && cpu_req_valid && cpu_req_ready && cpu_req_op == OP_WR)
    |=> (cpu_done && line_state == ST_M && !msg_out_valid));

endmodule

bind coh_line_ctl coh_line_ctl_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_op    (cpu_req_op),
  .cpu_req_ready (cpu_req_ready),
  .cpu_done      (cpu_done),
  .net_in_valid  (net_in_valid),
  .net_in_type   (net_in_type),
  .msg_out_valid (msg_out_valid),
  .msg_out_type  (msg_out_type),
  .line_state    (line_state),
  .proto_err     (proto_err)
);

// File: tb/test_coh_line_ctl.sv
module test_coh_line_ctl;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam logic [DW-1:0] WD = 8'hA5;
  localparam logic [DW-1:0] ND = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0;
  logic [1:0] cpu_req_op = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_stall, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic net_in_valid = 1'b0;
  logic [2:0] net_in_type = '0;
  logic [DW-1:0] net_in_data = '0;
  logic msg_out_valid;
  logic [2:0] msg_out_type;
  logic [DW-1:0] msg_out_data;
  logic [3:0] line_state;
  logic proto_err;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  coh_line_ctl #(.DW(DW)) i_coh_line_ctl (.*);

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req_valid = 1'b0;
    net_in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drv_cpu(int op, logic [DW-1:0] d);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_op = op[1:0];
    cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic drv_net(int ty, logic [DW-1:0] d);
    @(negedge clk);
    net_in_valid = 1'b1;
    net_in_type = ty[2:0];
    net_in_data = d;
    @(negedge clk);
    net_in_valid = 1'b0;
  endtask

  task automatic goto_state(int s);
    case (s)
      4:  drv_cpu(0, WD);
      5:  begin drv_cpu(0, WD); drv_net(0, ND); end
      1:  begin drv_cpu(0, WD); drv_net(4, ND); end
      6:  drv_cpu(1, WD);
      7:  begin drv_cpu(1, WD); drv_net(2, ND); end
      8:  begin drv_cpu(1, WD); drv_net(1, ND); end
      9:  begin drv_cpu(1, WD); drv_net(1, ND); drv_net(2, ND); end
      3:  begin drv_cpu(1, WD); drv_net(4, ND); end
      2:  begin drv_cpu(1, WD); drv_net(4, ND); drv_net(1, ND); end
      11: begin drv_cpu(1, WD); drv_net(4, ND); drv_cpu(2, WD); end
      10: begin drv_cpu(1, WD); drv_net(4, ND); drv_net(1, ND); drv_cpu(2, WD); end
      12: begin drv_cpu(1, WD); drv_net(4, ND); drv_net(1, ND); drv_cpu(1, WD); end
      default: ;
    endcase
  endtask

  // Expected reaction to a network message, from R3, R5, R7-R11
  task automatic net_model(input int s, input int t, output int nx, output bit snd,
                           output int sty, output bit flt, output bit dn);
    nx = s; snd = 0; sty = 0; flt = 1; dn = 0;
    case (s)
      1: if (t == 0) begin nx = 0; snd = 1; sty = 3; flt = 0; end
      2, 3: begin
        if (t == 1) begin nx = 2; snd = 1; sty = 4; flt = 0; end
        if (t == 2) begin nx = 0; snd = 1; sty = 4; flt = 0; end
      end
      4, 5: begin
        if (t == 0) begin nx = 5; snd = 1; sty = 3; flt = 0; end
        if (t == 4) begin nx = (s == 4) ? 1 : 0; dn = 1; flt = 0; end
      end
      6: begin
        if (t == 0) begin nx = 6; snd = 1; sty = 3; flt = 0; end
        if (t == 1) begin nx = 8; flt = 0; end
        if (t == 2) begin nx = 7; flt = 0; end
        if (t == 4) begin nx = 3; dn = 1; flt = 0; end
      end
      8: begin
        if (t == 0) begin nx = 7; snd = 1; sty = 3; flt = 0; end
        if (t == 2) begin nx = 9; flt = 0; end
        if (t == 4) begin nx = 2; snd = 1; sty = 4; dn = 1; flt = 0; end
      end
      7, 9: if (t == 4) begin nx = 0; snd = 1; sty = 4; dn = 1; flt = 0; end
      10, 11: begin
        if (t == 1) begin nx = s; snd = 1; sty = 4; flt = 0; end
        if (t == 2) begin nx = 0; snd = 1; sty = 4; flt = 0; end
        if (t == 3) begin nx = 0; flt = 0; end
      end
      12: begin
        if (t == 1) begin nx = 12; snd = 1; sty = 4; flt = 0; end
        if (t == 2) begin nx = 6; snd = 1; sty = 4; flt = 0; end
        if (t == 5) begin nx = 3; dn = 1; flt = 0; end
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(int s, bit flt);
    if (flt) return "R11";
    case (s)
      1: return "R3";
      2, 3: return "R5";
      4, 5: return "R7";
      6, 7, 8, 9: return "R8";
      10, 11: return "R9";
      12: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nx, sty;
    bit snd, flt, dn;
    string rq;

    do_reset();
    // R1 reset state
    chk("R1 state", line_state, 0);
    chk("R1 err", proto_err, 0);
    chk("R1 msg", msg_out_valid, 0);
    chk("R1 done", cpu_done, 0);

    // Sweep: every state against every network code
    for (int s = 0; s < 13; s++) begin
      for (int t = 0; t < 8; t++) begin
        do_reset();
        goto_state(s);
        drv_net(t, ND);
        net_model(s, t, nx, snd, sty, flt, dn);
        rq = tag_of(s, flt);
        chk(rq, line_state, nx);
        chk(rq, proto_err, flt);
        chk(rq, msg_out_valid, snd);
        if (snd) chk(rq, msg_out_type, sty);
        if (snd && sty == 4) chk(rq, msg_out_data, WD);
        chk(rq, cpu_done, dn);
        if (dn && (s == 4 || s == 5)) chk(rq, cpu_rdata, ND);
      end
    end

    // Processor ops in the stable states (R2, R3, R4, R11)
    for (int s = 0; s < 4; s++) begin
      for (int op = 0; op < 4; op++) begin
        int enx, ety;
        bit esnd, edn, eflt;
        logic [DW-1:0] erd;
        do_reset();
        goto_state(s);
        drv_cpu(op, 8'hC3);
        enx = s; esnd = 0; ety = 0; edn = 0; eflt = 0; erd = (s == 1) ? ND : WD;
        rq = (s == 0) ? "R2" : (s == 1) ? "R3" : "R4";
        if (op == 3) begin eflt = 1; rq = "R11"; end
        else if (op == 0) begin
          if (s == 0) begin enx = 4; esnd = 1; ety = 0; end
          else edn = 1;
        end else if (op == 1) begin
          case (s)
            0, 1: begin enx = 6; esnd = 1; ety = 1; end
            2: begin enx = 12; esnd = 1; ety = 1; end
            default: edn = 1;
          endcase
        end else begin
          case (s)
            2: begin enx = 10; esnd = 1; ety = 2; end
            3: begin enx = 11; esnd = 1; ety = 2; end
            default: enx = 0;
          endcase
        end
        chk(rq, line_state, enx);
        chk(rq, msg_out_valid, esnd);
        if (esnd) chk(rq, msg_out_type, ety);
        if (esnd && ety == 2) chk(rq, msg_out_data, WD);
        chk(rq, cpu_done, edn);
        if (edn && op == 0) chk(rq, cpu_rdata, erd);
        chk(rq, proto_err, eflt);
      end
    end

    // R4 write hit in M updates the line, seen by a later read
    do_reset();
    goto_state(3);
    drv_cpu(1, 8'h5E);
    drv_cpu(0, 8'h00);
    chk("R4 write hit data", cpu_rdata, 8'h5E);

    // R8 write miss completes, and the written value is read back
    do_reset();
    goto_state(6);
    drv_net(4, ND);
    drv_cpu(0, 8'h00);
    chk("R8 data after fill", cpu_rdata, WD);

    // R6 stall in every transient state
    for (int s = 4; s < 13; s++) begin
      do_reset();
      goto_state(s);
      @(negedge clk);
      chk("R6 stall", cpu_stall, 1);
      chk("R6 ready", cpu_req_ready, 0);
      drv_cpu(0, 8'h11);
      chk("R6 state held", line_state, s);
      chk("R6 no msg", msg_out_valid, 0);
      chk("R6 no done", cpu_done, 0);
    end
    do_reset();
    goto_state(3);
    @(negedge clk);
    chk("R6 stable no stall", cpu_stall, 0);

    // R12 network takes priority over a processor request
    do_reset();
    goto_state(3);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_op = 2'd1;
    cpu_req_wdata = 8'h77;
    net_in_valid = 1'b1;
    net_in_type = 3'd1;
    #1;
    chk("R12 ready low", cpu_req_ready, 0);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    net_in_valid = 1'b0;
    chk("R12 state", line_state, 2);
    chk("R12 msg type", msg_out_type, 4);
    chk("R12 msg data", msg_out_data, WD);
    chk("R12 no done", cpu_done, 0);

    // R11 sticky error
    do_reset();
    drv_net(0, ND);
    chk("R11 err set", proto_err, 1);
    drv_cpu(0, 8'h00);
    chk("R11 err held", proto_err, 1);
    chk("R11 still works", line_state, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule